// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt request lines from peripherals and one non-maskable line, and picks which request the processor should take next. Each maskable channel has a pending flag, an enable flag and a 4-bit priority, where a smaller number is more urgent. A programmable grouping divides the priority into a preemption part, which decides whether one handler may interrupt another, and a sub-priority part, which only orders requests that tie on preemption. A masking threshold can hold back requests that are not urgent enough.

The controller presents the byte address of the vector table entry for the winning request, along with a request-valid flag. The processor acknowledges the request when it enters the handler and pulses an exit strobe when the handler returns. An internal stack of running levels lets the controller nest handlers and restore the interrupted level on exit. When a handler exits and a waiting request already outranks the level being returned to, a tail flag tells the core that it can skip the unstack and restack.

Top module: `nvic_ctrl`

## Requirements
- R1: A rising edge on a request line sets the pending flag of that channel whether or not the channel is enabled. A pending channel that is disabled is never offered, and it is offered once it is enabled.
- R2: The offered address is 64 + 4n for maskable channel n, and 8 for the non-maskable request.
- R3: Among eligible pending channels the one with the smallest 4-bit priority value is offered. On equal values the lower channel number wins.
- R4: The grouping value g (written values above 4 count as 4) gives the number of low priority bits that form the sub-priority. The preemption level is the priority with those g bits cleared. A maskable request is offered only if its preemption level plus one is below the running rank, so sub-priority alone never preempts.
- R5: run_rank_o reports the running level: 17 when no handler is active, 0 for the non-maskable handler, and preemption level + 1 for a maskable handler.
- R6: ack_i while req_valid_o is high clears the pending flag of the offered request, and from the next clock run_rank_o shows that request's rank. ack_i while req_valid_o is low has no effect.
- R7: exit_i restores run_rank_o to the rank that was running before the most recent accepted ack. With no handler active, exit_i has no effect.
- R8: A threshold value T other than 0 makes a maskable channel eligible only when its full priority is below T. T = 0 turns the threshold off. Held channels stay pending.
- R9: The non-maskable request is pending on its rising edge and ignores enables and threshold. It outranks every maskable channel, and it cannot itself be preempted.
- R10: On an exit, if the request offered in that clock outranks the rank being restored, req_tail_o is high together with req_valid_o until the next accepted ack. Otherwise req_tail_o stays low.
- R11: After reset no request is offered, run_rank_o is 17 and req_tail_o is low. A request edge sampled at one clock edge appears on req_valid_o after the following clock edge, and a configuration change takes effect on the offer one clock after it is written.
- R12: A configuration write (cfg_we high) acts on the field selected by cfg_op: 0 sets the enable of channel cfg_idx from cfg_data[0], 1 sets its priority from cfg_data, 2 sets the grouping, and 3 sets the threshold. A channel write with cfg_idx of NUM_IRQ or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_IRQ | Maskable request lines, edge sensitive |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Configuration field select |
| cfg_idx | input | $clog2(NUM_IRQ) | Channel select for enable and priority writes |
| cfg_data | input | 4 | Configuration write data |
| ack_i | input | 1 | Processor takes the offered request |
| exit_i | input | 1 | Processor returns from the current handler |
| req_valid_o | output | 1 | A request outranks the running level |
| req_addr_o | output | ADDR_W | Vector table entry address of the offered request |
| req_tail_o | output | 1 | Offered request follows a handler exit directly |
| run_rank_o | output | 5 | Current running rank |

## Verification
The bench aims at the cases where grouping splits the priority. A request with a smaller full priority but the same preemption level must wait, and a design that compared full priorities would nest it at once. Ties on the full value check the lower-channel rule, and a design that scanned from the top would hand out the higher channel. Exits through two nesting levels show whether the stack restores the interrupted rank rather than the idle rank. The non-maskable line is driven under a blocking threshold and while its own handler runs; a design that applied the threshold to it, or that let it re-enter, would raise req_valid_o at the wrong time. A long random phase compares every output against a behavioural model on every clock to catch mistakes in the tail flag and in pending set and clear collisions.

// File: rtl/nvic_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, rank encoding and configuration opcodes
// for the nested priority interrupt controller.
// Assumes 4-bit priorities; a rank is 5 bits wide (0 = non-maskable,
// 1..16 = maskable preemption level + 1, 17 = idle).
package nvic_pkg;
    localparam int PRIO_W    = 4;
    localparam int RANK_W    = 5;
    localparam int GRP_W     = 3;
    localparam int MAX_SUB   = 4;
    localparam int VEC_BASE  = 64;
    localparam int NMI_ADDR  = 8;

    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam rank_t RANK_IDLE = rank_t'(17);
    localparam rank_t RANK_NMI  = rank_t'(0);

    typedef enum logic [1:0] {
        OP_ENABLE = 2'd0,
        OP_PRIO   = 2'd1,
        OP_GROUP  = 2'd2,
        OP_THRESH = 2'd3
    } cfg_op_e;

    // Rank of a maskable priority: clear the sub-priority bits, add one.
    function automatic rank_t prio_rank(input prio_t p, input logic [GRP_W-1:0] sub);
        prio_t sub_mask;
        sub_mask = prio_t'((5'd1 << sub) - 5'd1);
        return rank_t'({1'b0, p & ~sub_mask}) + rank_t'(1);
    endfunction
endpackage

// File: rtl/nvic_chan_bank.sv
`timescale 1ns/1ps
// Module: per-channel state bank. Holds pending, enable and priority for
// each maskable line. Pending is set by a rising edge of the line and
// cleared by the acknowledge of that channel; a new edge wins a collision.
// Assumes irq_i is synchronous to clk.
module nvic_chan_bank #(
    parameter int NUM_IRQ = 67,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_IRQ-1:0]                     irq_i,
    input  logic                                   cfg_we,
    input  logic [1:0]                             cfg_op,
    input  logic [IDX_W-1:0]                       cfg_idx,
    input  logic [nvic_pkg::PRIO_W-1:0]            cfg_data,
    input  logic                                   clr_en,
    input  logic [IDX_W-1:0]                       clr_idx,
    output logic [NUM_IRQ-1:0]                     pend_o,
    output logic [NUM_IRQ-1:0]                     en_o,
    output logic [NUM_IRQ-1:0][nvic_pkg::PRIO_W-1:0] prio_o
);
    import nvic_pkg::*;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ch
        logic  prev_q;
        logic  pend_q;
        logic  en_q;
        prio_t prio_q;
        logic  hit;
        logic  edge_seen;
        logic  clr_hit;

        // Decode whether this cycle's write or clear addresses this channel.
        always_comb begin
            hit       = cfg_we && (cfg_idx == IDX_W'(g));
            edge_seen = irq_i[g] && !prev_q;
            clr_hit   = clr_en && (clr_idx == IDX_W'(g));
        end

        // Track the line, the pending flag and the channel configuration.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                en_q   <= 1'b0;
                prio_q <= '0;
            end else begin
                prev_q <= irq_i[g];
                if (edge_seen)
                    pend_q <= 1'b1;
                else if (clr_hit)
                    pend_q <= 1'b0;
                if (hit && cfg_op == OP_ENABLE)
                    en_q <= cfg_data[0];
                if (hit && cfg_op == OP_PRIO)
                    prio_q <= cfg_data;
            end
        end

        assign pend_o[g] = pend_q;
        assign en_o[g]   = en_q;
        assign prio_o[g] = prio_q;
    end
endmodule

// File: rtl/nvic_select.sv
`timescale 1ns/1ps
// Module: registered arbiter. Finds the eligible pending channel with the
// smallest priority (lowest index on ties); a pending non-maskable request
// overrides all. The result is registered, so it lags its inputs by one clock.
// Assumes thresh = 0 means no threshold.
module nvic_select #(
    parameter int NUM_IRQ = 67,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_IRQ-1:0]                     pend_i,
    input  logic [NUM_IRQ-1:0]                     en_i,
    input  logic [NUM_IRQ-1:0][nvic_pkg::PRIO_W-1:0] prio_i,
    input  logic                                   nmi_pend_i,
    input  logic [nvic_pkg::GRP_W-1:0]             sub_bits_i,
    input  logic [nvic_pkg::PRIO_W-1:0]            thresh_i,
    output logic                                   cand_valid_o,
    output logic                                   cand_nmi_o,
    output logic [IDX_W-1:0]                       cand_idx_o,
    output logic [nvic_pkg::RANK_W-1:0]            cand_rank_o
);
    import nvic_pkg::*;

    logic             found;
    prio_t            best_prio;
    logic [IDX_W-1:0] best_idx;
    logic [NUM_IRQ-1:0] eligible;

    // Eligibility per channel: pending, enabled and above the threshold.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++)
            eligible[i] = pend_i[i] && en_i[i] &&
                          ((thresh_i == '0) || (prio_i[i] < thresh_i));
    end

    // Linear scan keeping the strictly smaller priority, so lower index wins ties.
    always_comb begin
        found     = 1'b0;
        best_prio = '1;
        best_idx  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (eligible[i] && (!found || prio_i[i] < best_prio)) begin
                found     = 1'b1;
                best_prio = prio_i[i];
                best_idx  = IDX_W'(i);
            end
        end
    end

    // Register the winner together with its rank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid_o <= 1'b0;
            cand_nmi_o   <= 1'b0;
            cand_idx_o   <= '0;
            cand_rank_o  <= RANK_IDLE;
        end else if (nmi_pend_i) begin
            cand_valid_o <= 1'b1;
            cand_nmi_o   <= 1'b1;
            cand_idx_o   <= '0;
            cand_rank_o  <= RANK_NMI;
        end else begin
            cand_valid_o <= found;
            cand_nmi_o   <= 1'b0;
            cand_idx_o   <= best_idx;
            cand_rank_o  <= found ? prio_rank(best_prio, sub_bits_i) : RANK_IDLE;
        end
    end
endmodule

// File: rtl/nvic_level_stack.sv
`timescale 1ns/1ps
// Module: stack of running ranks. Push on an accepted acknowledge, pop on
// handler exit. Exposes the current top and the rank one below it.
// Assumes pushed ranks strictly decrease, so DEPTH = 17 cannot overflow.
module nvic_level_stack #(
    parameter int DEPTH = 17
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [nvic_pkg::RANK_W-1:0]  push_rank_i,
    input  logic                         pop_i,
    output logic [nvic_pkg::RANK_W-1:0]  top_o,
    output logic [nvic_pkg::RANK_W-1:0]  below_o,
    output logic                         busy_o
);
    import nvic_pkg::*;

    localparam int PTR_W = $clog2(DEPTH + 1);

    rank_t            mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_m1;
    logic [PTR_W-1:0] ptr_m2;

    // Pointer arithmetic for the two readable slots.
    always_comb begin
        ptr_m1 = ptr - PTR_W'(1);
        ptr_m2 = ptr - PTR_W'(2);
    end

    // Move the pointer and store the pushed rank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (push_i && ptr < PTR_W'(DEPTH)) begin
            mem[ptr] <= push_rank_i;
            ptr      <= ptr + PTR_W'(1);
        end else if (pop_i && ptr != '0) begin
            ptr <= ptr_m1;
        end
    end

    // Read the top rank and the rank that a pop would restore.
    always_comb begin
        top_o   = (ptr == '0)          ? RANK_IDLE : mem[ptr_m1];
        below_o = (ptr < PTR_W'(2))    ? RANK_IDLE : mem[ptr_m2];
        busy_o  = (ptr != '0);
    end
endmodule

// File: rtl/nvic_ctrl.sv
`timescale 1ns/1ps
// Module: top of the nested priority interrupt controller. Holds the global
// configuration (grouping, threshold), the non-maskable pending flag and
// the tail flag, and ties together the channel bank, arbiter and stack.
// Assumes the processor raises ack_i only to take the offered request and
// exit_i once per handler return.
module nvic_ctrl #(
    parameter int NUM_IRQ     = 67,
    parameter int STACK_DEPTH = 17,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               nmi_i,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_op,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [3:0]         cfg_data,
    input  logic               ack_i,
    input  logic               exit_i,
    output logic               req_valid_o,
    output logic [ADDR_W-1:0]  req_addr_o,
    output logic               req_tail_o,
    output logic [4:0]         run_rank_o
);
    import nvic_pkg::*;

    logic [NUM_IRQ-1:0]             pend;
    logic [NUM_IRQ-1:0]             en;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;

    logic              nmi_prev_q;
    logic              nmi_pend_q;
    logic [GRP_W-1:0]  sub_bits_q;
    prio_t             thresh_q;
    logic              tail_q;

    logic              cand_valid;
    logic              cand_nmi;
    logic [IDX_W-1:0]  cand_idx;
    rank_t             cand_rank;

    rank_t             top_rank;
    rank_t             below_rank;
    logic              stack_busy;

    logic              offer;
    logic              take;
    logic              leave;

    // Handshake decode: offer when the candidate outranks the running level.
    always_comb begin
        offer = cand_valid && (cand_rank < top_rank);
        take  = ack_i && offer;
        leave = exit_i && !take && stack_busy;
    end

    nvic_chan_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_i),
        .cfg_we   (cfg_we),
        .cfg_op   (cfg_op),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .clr_en   (take && !cand_nmi),
        .clr_idx  (cand_idx),
        .pend_o   (pend),
        .en_o     (en),
        .prio_o   (prio)
    );

    nvic_select #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend),
        .en_i         (en),
        .prio_i       (prio),
        .nmi_pend_i   (nmi_pend_q),
        .sub_bits_i   (sub_bits_q),
        .thresh_i     (thresh_q),
        .cand_valid_o (cand_valid),
        .cand_nmi_o   (cand_nmi),
        .cand_idx_o   (cand_idx),
        .cand_rank_o  (cand_rank)
    );

    nvic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take),
        .push_rank_i (cand_rank),
        .pop_i       (leave),
        .top_o       (top_rank),
        .below_o     (below_rank),
        .busy_o      (stack_busy)
    );

    // Global configuration registers: grouping split and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_bits_q <= '0;
            thresh_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_op == OP_GROUP)
                sub_bits_q <= (cfg_data > 4'(MAX_SUB)) ? GRP_W'(MAX_SUB) : GRP_W'(cfg_data);
            if (cfg_op == OP_THRESH)
                thresh_q <= cfg_data;
        end
    end

    // Non-maskable pending flag: edge sets, its own acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            if (nmi_i && !nmi_prev_q)
                nmi_pend_q <= 1'b1;
            else if (take && cand_nmi)
                nmi_pend_q <= 1'b0;
        end
    end

    // Tail flag: set on an exit that an offered request already outranks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= 1'b0;
        else if (take)
            tail_q <= 1'b0;
        else if (leave)
            tail_q <= cand_valid && (cand_rank < below_rank);
    end

    // Output formatting: vector entry address and running rank.
    always_comb begin
        req_valid_o = offer;
        req_tail_o  = tail_q && offer;
        run_rank_o  = top_rank;
        if (cand_nmi)
            req_addr_o = ADDR_W'(NMI_ADDR);
        else
            req_addr_o = ADDR_W'(VEC_BASE) + (ADDR_W'(cand_idx) << 2);
    end
endmodule

// File: rtl/nvic_ctrl_chk.sv
`timescale 1ns/1ps
// Module: property checker for nvic_ctrl, attached with bind below.
// Observes only the top-level ports.
module nvic_ctrl_chk #(
    parameter int NUM_IRQ = 67,
    parameter int ADDR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              exit_i,
    input logic              req_valid_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic              req_tail_o,
    input logic [4:0]        run_rank_o
);
    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o == ADDR_W'(8)) ||
                        (req_addr_o >= ADDR_W'(64) &&
                         req_addr_o < ADDR_W'(64 + 4 * NUM_IRQ) &&
                         req_addr_o[1:0] == 2'b00));

    // R6
    ack_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_valid_o) |=> (run_rank_o < $past(run_rank_o)));

    // R7
    exit_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !(ack_i && req_valid_o) && run_rank_o != 5'd17)
            |=> (run_rank_o > $past(run_rank_o)));

    // R5
    rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && req_valid_o) && !exit_i) |=> $stable(run_rank_o));

    // R5
    rank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_rank_o <= 5'd17);

    // R9
    nmi_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_rank_o == 5'd0) |-> !req_valid_o);

    // R10
    tail_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_tail_o |-> req_valid_o);
endmodule

bind nvic_ctrl nvic_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .exit_i      (exit_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_tail_o  (req_tail_o),
    .run_rank_o  (run_rank_o)
);

// File: tb/nvic_ctrl_test.sv
`timescale 1ns/1ps
module nvic_ctrl_test;
    localparam int NI = 67;
    localparam int IW = $clog2(NI);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_i = '0;
    logic          nmi_i = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [3:0]    cfg_data = '0;
    logic          ack_i = 1'b0;
    logic          exit_i = 1'b0;
    logic          req_valid_o;
    logic [31:0]   req_addr_o;
    logic          req_tail_o;
    logic [4:0]    run_rank_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nvic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .ack_i(ack_i), .exit_i(exit_i), .req_valid_o(req_valid_o),
        .req_addr_o(req_addr_o), .req_tail_o(req_tail_o), .run_rank_o(run_rank_o)
    );

    // ---------------- behavioural reference model ----------------
    bit m_pend [NI];
    bit m_en   [NI];
    int m_pr   [NI];
    bit m_prev [NI];
    bit m_npend, m_nprev, m_tail;
    int m_sub, m_thr;
    bit c_v, c_n;
    int c_i, c_r;
    int stk[$];
    bit fire, nv, nn;
    int ni, nr, bp;

    function automatic int m_top();
        return (stk.size() > 0) ? stk[stk.size()-1] : 17;
    endfunction

    function automatic bit m_valid();
        return c_v && (c_r < m_top());
    endfunction

    function automatic int m_addr();
        return c_n ? 8 : 64 + 4 * c_i;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin
                m_pend[i] = 0; m_en[i] = 0; m_pr[i] = 0; m_prev[i] = 0;
            end
            m_npend = 0; m_nprev = 0; m_tail = 0; m_sub = 0; m_thr = 0;
            c_v = 0; c_n = 0; c_i = 0; c_r = 17;
            stk.delete();
        end else begin
            fire = ack_i && m_valid();
            nv = 0; nn = 0; ni = 0; nr = 17; bp = 16;
            if (m_npend) begin
                nv = 1; nn = 1; nr = 0;
            end else begin
                for (int i = 0; i < NI; i++)
                    if (m_pend[i] && m_en[i] && (m_thr == 0 || m_pr[i] < m_thr) && m_pr[i] < bp) begin
                        bp = m_pr[i]; ni = i; nv = 1;
                    end
                if (nv) nr = (bp & ~((1 << m_sub) - 1)) + 1;
            end
            if (fire) begin
                stk.push_back(c_r);
                m_tail = 0;
                if (c_n) m_npend = 0; else m_pend[c_i] = 0;
            end else if (exit_i && stk.size() > 0) begin
                void'(stk.pop_back());
                m_tail = c_v && (c_r < m_top());
            end
            for (int i = 0; i < NI; i++) begin
                if (irq_i[i] && !m_prev[i]) m_pend[i] = 1;
                m_prev[i] = irq_i[i];
            end
            if (nmi_i && !m_nprev) m_npend = 1;
            m_nprev = nmi_i;
            if (cfg_we) begin
                case (cfg_op)
                    2'd0: if (int'(cfg_idx) < NI) m_en[cfg_idx] = cfg_data[0];
                    2'd1: if (int'(cfg_idx) < NI) m_pr[cfg_idx] = int'(cfg_data);
                    2'd2: m_sub = (cfg_data > 4) ? 4 : int'(cfg_data);
                    default: m_thr = int'(cfg_data);
                endcase
            end
            c_v = nv; c_n = nn; c_i = ni; c_r = nr;
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (req_valid_o !== m_valid()) begin
                bad++;
                $display("FAIL R4 model valid act=%0d exp=%0d t=%0t", req_valid_o, m_valid(), $time);
            end
            total++;
            if (int'(run_rank_o) != m_top()) begin
                bad++;
                $display("FAIL R7 model rank act=%0d exp=%0d t=%0t", run_rank_o, m_top(), $time);
            end
            total++;
            if (req_tail_o !== (m_tail && m_valid())) begin
                bad++;
                $display("FAIL R10 model tail act=%0d exp=%0d t=%0t", req_tail_o, m_tail && m_valid(), $time);
            end
            if (m_valid()) begin
                total++;
                if (int'(req_addr_o) != m_addr()) begin
                    bad++;
                    $display("FAIL R3 model addr act=%0d exp=%0d t=%0t", req_addr_o, m_addr(), $time);
                end
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_out(string tag, int v, int addr, int rank);
        chk({tag, " valid"}, int'(req_valid_o), v);
        if (addr >= 0) chk({tag, " addr"}, int'(req_addr_o), addr);
        chk({tag, " rank"}, int'(run_rank_o), rank);
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg(int op, int idx, int data);
        cfg_we = 1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_data = 4'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic setup(int ch, int pr);
        cfg(1, ch, pr);
        cfg(0, ch, 1);
    endtask

    task automatic pulse(int ch);
        irq_i[ch] = 1'b1;
        @(negedge clk);
        irq_i[ch] = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1; @(negedge clk); ack_i = 0;
    endtask

    task automatic do_exit();
        exit_i = 1; @(negedge clk); exit_i = 0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        wait_n(4);
        rst_n = 1;
        // R11 reset state
        expect_out("R11 reset", 0, -1, 17);
        chk("R11 reset tail", int'(req_tail_o), 0);

        // R1 / R12: disabled channel stays pending, enable releases it
        cfg(1, 9, 5);
        pulse(9);
        wait_n(3);
        expect_out("R1 disabled held", 0, -1, 17);
        cfg(0, 9, 1);
        expect_out("R11 enable latency", 0, -1, 17);
        wait_n(1);
        expect_out("R2 channel 9 address", 1, 100, 17);

        // R6 acknowledge
        do_ack();
        expect_out("R6 ack rank", 0, -1, 6);

        // R4 preemption by a smaller preemption level, then R7 exits
        setup(3, 3);
        pulse(3);
        expect_out("R11 edge latency", 0, -1, 6);
        wait_n(1);
        expect_out("R4 preempt offer", 1, 76, 6);
        do_ack();
        expect_out("R6 nested rank", 0, -1, 4);
        do_exit();
        expect_out("R7 restore", 0, -1, 6);
        do_exit();
        expect_out("R7 idle", 0, -1, 17);
        do_exit();
        expect_out("R7 empty exit", 0, -1, 17);
        ack_i = 1; wait_n(1); ack_i = 0;
        expect_out("R6 ack ignored", 0, -1, 17);

        // R4 grouping: two sub bits
        cfg(2, 0, 2);
        pulse(9);
        wait_n(2);
        do_ack();
        expect_out("R5 grouped rank", 0, -1, 5);
        setup(4, 6);
        pulse(4);
        wait_n(3);
        expect_out("R4 sub no preempt", 0, -1, 5);
        setup(5, 3);
        pulse(5);
        wait_n(2);
        expect_out("R4 group preempt", 1, 84, 5);
        do_ack();
        expect_out("R5 rank one", 0, -1, 1);
        do_exit();
        expect_out("R10 no tail", 0, -1, 5);
        chk("R10 no tail flag", int'(req_tail_o), 0);
        do_exit();
        expect_out("R10 tail offer", 1, 80, 17);
        chk("R10 tail flag", int'(req_tail_o), 1);
        do_ack();
        chk("R10 tail cleared", int'(req_tail_o), 0);
        do_exit();

        // R3 ordering with ties
        setup(10, 7);
        setup(11, 6);
        setup(12, 6);
        irq_i[10] = 1; irq_i[11] = 1; irq_i[12] = 1;
        wait_n(1);
        irq_i[10] = 0; irq_i[11] = 0; irq_i[12] = 0;
        wait_n(2);
        expect_out("R3 lower channel on tie", 1, 108, 17);
        do_ack();
        do_exit();
        expect_out("R3 next tie", 1, 112, 17);
        do_ack();
        do_exit();
        expect_out("R3 larger value last", 1, 104, 17);
        do_ack();
        do_exit();
        cfg(2, 0, 9);
        cfg(2, 0, 0);

        // R8 threshold
        cfg(3, 0, 4);
        setup(20, 5);
        pulse(20);
        wait_n(3);
        expect_out("R8 held", 0, -1, 17);
        setup(21, 2);
        pulse(21);
        wait_n(2);
        expect_out("R8 passes", 1, 148, 17);
        do_ack();
        do_exit();
        cfg(3, 0, 0);
        wait_n(1);
        expect_out("R8 released", 1, 144, 17);
        do_ack();
        do_exit();

        // R9 non-maskable
        pulse(3);
        wait_n(2);
        do_ack();
        cfg(3, 0, 1);
        pulse_nmi();
        wait_n(1);
        expect_out("R9 nmi offer", 1, 8, 4);
        do_ack();
        expect_out("R9 nmi rank", 0, -1, 0);
        pulse_nmi();
        wait_n(3);
        expect_out("R9 nmi no reentry", 0, -1, 0);
        do_exit();
        expect_out("R9 nmi after exit", 1, 8, 4);
        chk("R10 nmi tail", int'(req_tail_o), 1);
        do_ack();
        do_exit();
        do_exit();
        cfg(3, 0, 0);
        cfg(0, 100, 1);
        expect_out("R12 out of range", 0, -1, 17);

        // Random phase compared against the model
        for (int ch = 0; ch < NI; ch++) setup(ch, $urandom % 16);
        for (int cyc = 0; cyc < 20000; cyc++) begin
            for (int b = 0; b < NI; b++)
                if ($urandom % 40 == 0) irq_i[b] = ~irq_i[b];
            nmi_i  = ($urandom % 300 == 0) ? ~nmi_i : nmi_i;
            ack_i  = req_valid_o && ($urandom % 3 == 0);
            exit_i = ($urandom % 5 == 0);
            cfg_we = ($urandom % 25 == 0);
            cfg_op = 2'($urandom % 4);
            cfg_idx = IW'($urandom % 70);
            cfg_data = 4'($urandom % 16);
            if (cfg_op == 2'd3) cfg_data = 4'($urandom % 2 == 0 ? 0 : cfg_data);
            @(negedge clk);
        end
        ack_i = 0; exit_i = 0; cfg_we = 0;
        wait_n(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R11 watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule